// File: doc/BRIEF.md
# Command-Sequence Write-Protect Guard

This block sits beside the write sequencer of a byte-wide nonvolatile memory and watches every write the sequencer accepts. Each write is an address and data pair. The block holds a protection flag that is clear after reset. A short key of three address and data writes sets the flag. The same key, sent while the flag is already set, unlocks data writes for one load window. A longer key of six writes clears the flag.

For the write that is present in a given cycle, the block returns two combinational decisions to the sequencer. The permit signal lets the sequencer store the byte. The discard signal marks the byte as part of a key sequence, and the sequencer must not store it. A load window timer restarts on every accepted write. When the timer runs out with no further write, the block drops any partly matched key and any unlock grant it holds.

Top module: `wpu_cmd_guard`

## Requirements
- R1: After reset `prot_on` is 0. A write that is not part of a key sequence asserts `wr_permit` in its own cycle, with `wr_discard` low, while protection is off.
- R2: The arm key is three writes in a row: data 0xAA at key address 0x5555, then 0x55 at 0x2AAA, then 0xA0 at 0x5555. `wr_discard` is high and `wr_permit` is low in the cycle of each of these writes. `prot_on` is 1 from the cycle after the third write.
- R3: Once set, `prot_on` stays 1 when the load window expires and no data write follows. Only the clear key changes it.
- R4: While `prot_on` is 1 and no unlock grant is held, an ordinary write gets `wr_permit`=0 and `wr_discard`=0.
- R5: A complete arm key grants an unlock. Ordinary writes that follow it inside the load window get `wr_permit`=1 while protection is on.
- R6: The load window is WIN_CYCLES clock cycles long and restarts on every write. A write in the WIN_CYCLES-th cycle after the previous write is still inside the window. If no write arrives in that cycle, the grant is gone from the next cycle on.
- R7: The clear key is six writes: 0xAA at 0x5555, 0x55 at 0x2AAA, 0x80 at 0x5555, 0xAA at 0x5555, 0x55 at 0x2AAA, 0x20 at 0x5555. All six are discarded. `prot_on` is 0 from the cycle after the sixth, and ordinary writes are permitted again.
- R8: A write that does not continue a partly matched key returns the matcher to idle. That write is judged as an ordinary write (not discarded, permitted only if protection is off or granted). A later write that would have continued the broken key is also ordinary.
- R9: Only address bits 14 down to 0 take part in the key compare. Higher address bits are ignored.
- R10: Load window expiry in the middle of a key returns the matcher to idle, so the remaining key writes are treated as ordinary writes.
- R11: `wr_permit` and `wr_discard` are never high together, and neither is high without `wr_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| wr_valid | input | 1 | A write is accepted by the sequencer this cycle |
| wr_addr | input | ADDR_W | Address of the accepted write |
| wr_data | input | 8 | Data byte of the accepted write |
| prot_on | output | 1 | Protection flag |
| wr_permit | output | 1 | Store the current write |
| wr_discard | output | 1 | Current write is a key byte; do not store it |

## Verification
The bench builds the block with ADDR_W=16 and WIN_CYCLES=8. The spare top address bit lets key writes be sent with bit 15 set, which exercises the masked address compare. The short window makes expiry reachable within a few cycles. With it, the bench can place a write exactly on the last cycle of the window, one cycle past it, and in the middle of a partly sent key.

// File: rtl/wpu_pkg.sv
package wpu_pkg;
  localparam int KEY_AW = 15;

  typedef logic [KEY_AW-1:0] key_addr_t;
  typedef logic [7:0]        key_byte_t;

  // matcher position: number of key writes already matched
  typedef enum logic [2:0] {
    SEQ_IDLE = 3'd0,
    SEQ_K1   = 3'd1,
    SEQ_K2   = 3'd2,
    SEQ_D3   = 3'd3,
    SEQ_D4   = 3'd4,
    SEQ_D5   = 3'd5
  } seq_t;

  localparam key_addr_t KA_ODD  = 15'h5555;
  localparam key_addr_t KA_EVEN = 15'h2AAA;
  localparam key_byte_t KB_OPEN  = 8'hAA;
  localparam key_byte_t KB_TWO   = 8'h55;
  localparam key_byte_t KB_ARM   = 8'hA0;
  localparam key_byte_t KB_ESC   = 8'h80;
  localparam key_byte_t KB_CLEAR = 8'h20;

  typedef struct packed {
    logic hit;
    logic arm_done;
    logic clear_done;
    seq_t nxt;
  } match_t;
endpackage

// File: rtl/wpu_key_match.sv
module wpu_key_match
  import wpu_pkg::*;
(
  input  seq_t      cur,
  input  key_addr_t addr,
  input  key_byte_t data,
  output match_t    res
);
  logic at_odd, at_even;

  assign at_odd  = (addr == KA_ODD);
  assign at_even = (addr == KA_EVEN);

  always_comb begin
    res = '{hit: 1'b0, arm_done: 1'b0, clear_done: 1'b0, nxt: SEQ_IDLE};
    unique case (cur)
      SEQ_IDLE, SEQ_D3: begin
        if (at_odd && data == KB_OPEN) begin
          res.hit = 1'b1;
          res.nxt = (cur == SEQ_IDLE) ? SEQ_K1 : SEQ_D4;
        end
      end
      SEQ_K1, SEQ_D4: begin
        if (at_even && data == KB_TWO) begin
          res.hit = 1'b1;
          res.nxt = (cur == SEQ_K1) ? SEQ_K2 : SEQ_D5;
        end
      end
      SEQ_K2: begin
        if (at_odd && data == KB_ARM) begin
          res.hit      = 1'b1;
          res.arm_done = 1'b1;
        end else if (at_odd && data == KB_ESC) begin
          res.hit = 1'b1;
          res.nxt = SEQ_D3;
        end
      end
      SEQ_D5: begin
        if (at_odd && data == KB_CLEAR) begin
          res.hit        = 1'b1;
          res.clear_done = 1'b1;
        end
      end
      default: res.hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/wpu_load_window.sv
module wpu_load_window #(
  parameter int WIN_CYCLES = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expire
);
  localparam int CW = $clog2(WIN_CYCLES + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(WIN_CYCLES);
  localparam logic [CW-1:0] CNT_ONE  = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = CNT_FULL;
    else if (cnt_q != '0)
      cnt_d = cnt_q - CNT_ONE;
  end

  assign cnt_en = load || (cnt_q != '0);
  assign expire = !load && (cnt_q == CNT_ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wpu_cmd_guard.sv
module wpu_cmd_guard
  import wpu_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int WIN_CYCLES = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              prot_on,
  output logic              wr_permit,
  output logic              wr_discard
);
  seq_t      seq_q, seq_d;
  logic      grant_q, grant_d;
  logic      prot_q, prot_d;
  logic      win_expire;
  logic      upd_en;
  key_addr_t key_addr;
  match_t    mres;

  assign key_addr = wr_addr[KEY_AW-1:0];

  wpu_key_match u_match (
    .cur  (seq_q),
    .addr (key_addr),
    .data (wr_data),
    .res  (mres)
  );

  wpu_load_window #(.WIN_CYCLES(WIN_CYCLES)) u_window (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (wr_valid),
    .expire (win_expire)
  );

  assign wr_discard = wr_valid && mres.hit;
  assign wr_permit  = wr_valid && !mres.hit && (!prot_q || grant_q);
  assign prot_on    = prot_q;

  always_comb begin
    seq_d   = seq_q;
    grant_d = grant_q;
    prot_d  = prot_q;
    if (win_expire) begin
      seq_d   = SEQ_IDLE;
      grant_d = 1'b0;
    end
    if (wr_valid) begin
      if (mres.hit) begin
        seq_d = mres.nxt;
        if (mres.arm_done) begin
          prot_d  = 1'b1;
          grant_d = 1'b1;
        end
        if (mres.clear_done) begin
          prot_d  = 1'b0;
          grant_d = 1'b0;
        end
      end else begin
        seq_d = SEQ_IDLE;
      end
    end
  end

  assign upd_en = wr_valid || win_expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q   <= SEQ_IDLE;
      grant_q <= 1'b0;
      prot_q  <= 1'b0;
    end else if (upd_en) begin
      seq_q   <= seq_d;
      grant_q <= grant_d;
      prot_q  <= prot_d;
    end
  end
endmodule

// File: rtl/wpu_cmd_guard_chk.sv
module wpu_cmd_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_valid,
  input logic wr_permit,
  input logic wr_discard,
  input logic prot_on,
  input logic win_expire,
  input logic grant_q
);
  // R11
  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_permit && wr_discard));
  // R11
  a_r11_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_permit || wr_discard) |-> wr_valid);
  // R2
  a_r2_arm_after_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prot_on) |-> $past(wr_discard));
  // R7
  a_r7_clear_after_key: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prot_on) |-> $past(wr_discard));
  // R3
  a_r3_flag_moves_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prot_on) |-> $past(wr_valid));
  // R1
  a_r1_open_when_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !prot_on && !wr_discard) |-> wr_permit);
  // R6
  a_r6_expiry_drops_grant: assert property (@(posedge clk) disable iff (!rst_n)
    win_expire |=> !grant_q);
endmodule

bind wpu_cmd_guard wpu_cmd_guard_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_valid   (wr_valid),
  .wr_permit  (wr_permit),
  .wr_discard (wr_discard),
  .prot_on    (prot_on),
  .win_expire (win_expire),
  .grant_q    (grant_q)
);

// File: tb/wpu_cmd_guard_tb.sv
module wpu_cmd_guard_tb;
  localparam int AW  = 16;
  localparam int WIN = 8;

  logic          clk;
  logic          rst_n;
  logic          wr_valid;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;
  logic          prot_on, wr_permit, wr_discard;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural reference state
  int unsigned hist[$];
  int unsigned ena_key[$];
  int unsigned dis_key[$];
  bit m_prot  = 0;
  bit m_grant = 0;
  int idle    = WIN + 1;

  wpu_cmd_guard #(.ADDR_W(AW), .WIN_CYCLES(WIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .prot_on(prot_on), .wr_permit(wr_permit),
    .wr_discard(wr_discard)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  function automatic int unsigned kv(int unsigned a, int unsigned d);
    return ((a & 32'h7FFF) << 8) | (d & 32'hFF);
  endfunction

  function automatic bit is_prefix(int unsigned c[$], int unsigned l[$]);
    if (c.size() > l.size()) return 0;
    foreach (c[i]) if (c[i] != l[i]) return 0;
    return 1;
  endfunction

  task automatic chk(input string tag, input string nm, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, nm, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit v, input logic [15:0] a, input logic [7:0] d, input string tag);
    int unsigned cand[$];
    bit e_disc;
    bit e_perm;
    @(negedge clk);
    wr_valid = v; wr_addr = a; wr_data = d;
    #2;
    e_disc = 0; e_perm = 0;
    cand = hist;
    if (v) begin
      cand.push_back(kv(a, d));
      if (is_prefix(cand, ena_key) || is_prefix(cand, dis_key)) e_disc = 1;
      else e_perm = !m_prot || m_grant;
    end
    chk(tag, "prot_on", prot_on, m_prot);
    chk(tag, "wr_permit", wr_permit, e_perm);
    chk(tag, "wr_discard", wr_discard, e_disc);
    if (v) begin
      idle = 0;
      if (e_disc) begin
        if (cand.size() == 3 && is_prefix(cand, ena_key)) begin
          m_prot = 1; m_grant = 1; hist.delete();
        end else if (cand.size() == 6) begin
          m_prot = 0; m_grant = 0; hist.delete();
        end else hist = cand;
      end else hist.delete();
    end else begin
      idle++;
      if (idle == WIN) begin
        hist.delete(); m_grant = 0;
      end
    end
  endtask

  task automatic idle_n(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 16'h0, 8'h0, tag);
  endtask

  task automatic arm_key(input logic [15:0] hi, input string tag);
    cyc(1, 16'h5555 | hi, 8'hAA, tag);
    cyc(1, 16'h2AAA | hi, 8'h55, tag);
    cyc(1, 16'h5555 | hi, 8'hA0, tag);
  endtask

  task automatic clear_key(input string tag);
    cyc(1, 16'h5555, 8'hAA, tag);
    cyc(1, 16'h2AAA, 8'h55, tag);
    cyc(1, 16'h5555, 8'h80, tag);
    cyc(1, 16'h5555, 8'hAA, tag);
    cyc(1, 16'h2AAA, 8'h55, tag);
    cyc(1, 16'h5555, 8'h20, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 20000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    ena_key = '{kv(16'h5555, 8'hAA), kv(16'h2AAA, 8'h55), kv(16'h5555, 8'hA0)};
    dis_key = '{kv(16'h5555, 8'hAA), kv(16'h2AAA, 8'h55), kv(16'h5555, 8'h80),
                kv(16'h5555, 8'hAA), kv(16'h2AAA, 8'h55), kv(16'h5555, 8'h20)};
    rst_n = 0; wr_valid = 0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    chk("R1", "prot_on in reset", prot_on, 1'b0);
    rst_n = 1;

    // R1: ordinary writes while unprotected
    cyc(1, 16'h0123, 8'h3C, "R1");
    cyc(1, 16'h7FFF, 8'hAA, "R1");
    idle_n(2, "R1");

    // R8: broken key while unprotected, breaker is still stored
    cyc(1, 16'h5555, 8'hAA, "R8");
    cyc(1, 16'h1234, 8'h77, "R8");
    cyc(1, 16'h2AAA, 8'h55, "R8");
    idle_n(WIN + 1, "R8");

    // R2 + R9: arm key sent with address bit 15 set
    arm_key(16'h8000, "R9");
    // R5: data inside window
    cyc(1, 16'h0040, 8'h11, "R5");
    cyc(1, 16'h0041, 8'h22, "R5");
    // R3: window runs out, flag stays set
    idle_n(WIN + 2, "R3");
    // R4: no unlock
    cyc(1, 16'h0042, 8'h33, "R4");
    idle_n(WIN + 1, "R4");

    // R6: write on the last cycle of the window is permitted
    arm_key(16'h0000, "R5");
    idle_n(WIN - 1, "R6");
    cyc(1, 16'h0100, 8'h44, "R6");
    // R6: one cycle past the window is blocked
    idle_n(WIN, "R6");
    cyc(1, 16'h0101, 8'h45, "R6");
    idle_n(WIN + 1, "R6");

    // R8: broken key while protected
    cyc(1, 16'h5555, 8'hAA, "R8");
    cyc(1, 16'h0200, 8'h12, "R8");
    cyc(1, 16'h2AAA, 8'h55, "R8");
    cyc(1, 16'h5555, 8'hA0, "R8");
    idle_n(WIN + 1, "R8");

    // R10: expiry in the middle of a key
    cyc(1, 16'h5555, 8'hAA, "R10");
    cyc(1, 16'h2AAA, 8'h55, "R10");
    idle_n(WIN, "R10");
    cyc(1, 16'h5555, 8'hA0, "R10");
    cyc(1, 16'h0300, 8'h66, "R10");
    idle_n(WIN + 1, "R10");

    // R7: clear key, then writes open again
    clear_key("R7");
    cyc(1, 16'h0400, 8'h99, "R7");
    idle_n(WIN + 3, "R7");
    cyc(1, 16'h0401, 8'h9A, "R11");
    idle_n(2, "R11");

    finish_run();
  end
endmodule